// File: doc/BRIEF.md
# Stack Pointer Shadow Tracker

This block follows a processor's stack pointer purely from a stream of decoded instruction records, with no view of the address bus. Each record carries an operation class and, for an immediate load of X, the byte that was loaded. Calls, returns, interrupt entries and exits, pushes and pulls shift the stack pointer by a fixed amount. The only way to learn its absolute value is a transfer from X into the stack pointer at a moment when X itself is known.

Until that happens, the tracker runs in a relative state. It reports a signed offset counted from the start of the trace, for example -2 after one call. Once it holds an absolute value, it reports that byte and marks the offset invalid. From then on every delta wraps modulo 256. To decide whether X is known, the block keeps a small shadow of X. An immediate load makes X known. A copy of the stack pointer into X takes on the stack pointer's known state. A copy of A into X makes X unknown.

The control is a two-state machine. **ST_REL** is the reset state, in which the offset accumulates. **ST_ABS** is the state in which the absolute byte is tracked. Transitions: ST_REL to ST_ABS on a stack-pointer load while X is known; ST_ABS to ST_REL on a stack-pointer load while X is unknown (the offset restarts at zero); a stack-pointer load with X known while in ST_ABS stays in ST_ABS with the new value. Every other record stays in the current state.

Top module: `sp_shadow_tracker`

## Requirements
- R1: After reset, sp_known is 0, sp_value is 0, sp_offset is 0 and offset_valid is 1.
- R2: A call record (rec_op 1) lowers the stack pointer by 2, and a return record (rec_op 2) raises it by 2. The change applies to the offset in ST_REL and to the absolute byte in ST_ABS, and is visible one cycle after the record.
- R3: An interrupt-return record (rec_op 3) raises the stack pointer by 3, and a break or interrupt-entry record (rec_op 4) lowers it by 3.
- R4: A push record (rec_op 5) lowers the stack pointer by 1, and a pull record (rec_op 6) raises it by 1.
- R5: An immediate load of X (rec_op 7, value on rec_data) followed by a stack-pointer load from X (rec_op 10) sets sp_known to 1 and sp_value to the loaded byte. offset_valid then goes to 0, and sp_offset reads 0 while the value is known.
- R6: A copy of the stack pointer into X (rec_op 9) while the stack pointer is known makes X known with the current stack-pointer value, so a later rec_op 10 restores that value.
- R7: A copy of A into X (rec_op 8) makes X unknown. A rec_op 10 with X unknown returns the tracker to ST_REL with sp_known 0, offset 0 and offset_valid 1.
- R8: In ST_ABS, deltas wrap modulo 256 (0x05 after six pushes reads 0xFF).
- R9: In ST_REL, the offset is a two's-complement value of OFS_W bits that wraps modulo 2^OFS_W.
- R10: A record with rec_valid low, or with rec_op 0 or 11 to 15, changes no output and no X state.
- R11: A rec_op 9 while the stack pointer is unknown makes X unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Instruction record present this cycle |
| rec_op | input | 4 | Operation class of the record |
| rec_data | input | 8 | Immediate byte for an X load |
| sp_known | output | 1 | Absolute stack pointer value is known |
| sp_value | output | 8 | Absolute stack pointer (0 while unknown) |
| sp_offset | output | OFS_W | Signed offset since trace start (0 while known) |
| offset_valid | output | 1 | sp_offset is meaningful |

## Verification
The bench builds the tracker with OFS_W set to 6 instead of the default 16. This brings the relative offset's wrap within reach of seventeen calls, and random streams cross it often. Random record streams move freely between ST_REL and ST_ABS, because about one record in sixteen is a stack-pointer load. Directed sequences cover the 8-bit wrap, the restoring of a copied value, and loads with X unknown.

// File: rtl/sp_shadow_pkg.sv
package sp_shadow_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE    = 4'd0,
        OP_CALL    = 4'd1,
        OP_RET     = 4'd2,
        OP_RTI     = 4'd3,
        OP_BREAK   = 4'd4,
        OP_PUSH    = 4'd5,
        OP_PULL    = 4'd6,
        OP_LDX_IMM = 4'd7,
        OP_XFER_AX = 4'd8,
        OP_XFER_SX = 4'd9,
        OP_XFER_XS = 4'd10
    } rec_op_e;

    typedef enum logic {
        ST_REL = 1'b0,
        ST_ABS = 1'b1
    } trk_state_e;

    localparam int DELTA_W = 4;
endpackage

// File: rtl/sp_delta_decode.sv
module sp_delta_decode
    import sp_shadow_pkg::*;
(
    input  logic                      rec_valid,
    input  logic [OP_W-1:0]           rec_op,
    output logic signed [DELTA_W-1:0] delta
);
    always_comb begin
        delta = '0;
        if (rec_valid) begin
            case (rec_op)
                OP_CALL:  delta = -4'sd2;
                OP_RET:   delta =  4'sd2;
                OP_RTI:   delta =  4'sd3;
                OP_BREAK: delta = -4'sd3;
                OP_PUSH:  delta = -4'sd1;
                OP_PULL:  delta =  4'sd1;
                default:  delta = '0;
            endcase
        end
    end
endmodule

// File: rtl/x_shadow.sv
module x_shadow
    import sp_shadow_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec_valid,
    input  logic [OP_W-1:0] rec_op,
    input  logic [7:0]      rec_data,
    input  logic            sp_is_known,
    input  logic [7:0]      sp_abs,
    output logic            x_known,
    output logic [7:0]      x_value
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_known <= 1'b0;
            x_value <= 8'd0;
        end else if (rec_valid) begin
            case (rec_op)
                OP_LDX_IMM: begin
                    x_known <= 1'b1;
                    x_value <= rec_data;
                end
                OP_XFER_AX: x_known <= 1'b0;
                OP_XFER_SX: begin
                    x_known <= sp_is_known;
                    x_value <= sp_abs;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sp_shadow_tracker.sv
module sp_shadow_tracker
    import sp_shadow_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rec_valid,
    input  logic [3:0]              rec_op,
    input  logic [7:0]              rec_data,
    output logic                    sp_known,
    output logic [7:0]              sp_value,
    output logic signed [OFS_W-1:0] sp_offset,
    output logic                    offset_valid
);
    localparam int EXT_OFS = OFS_W - DELTA_W;
    localparam int EXT_ABS = 8 - DELTA_W;

    trk_state_e                state_q, state_d;
    logic [7:0]                abs_q;
    logic signed [OFS_W-1:0]   ofs_q;
    logic signed [DELTA_W-1:0] delta;
    logic                      x_known;
    logic [7:0]                x_value;
    logic                      load_sp;

    assign load_sp = rec_valid && (rec_op == OP_XFER_XS);

    sp_delta_decode u_delta (
        .rec_valid (rec_valid),
        .rec_op    (rec_op),
        .delta     (delta)
    );

    x_shadow u_xs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rec_valid   (rec_valid),
        .rec_op      (rec_op),
        .rec_data    (rec_data),
        .sp_is_known (state_q == ST_ABS),
        .sp_abs      (abs_q),
        .x_known     (x_known),
        .x_value     (x_value)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REL: if (load_sp && x_known)  state_d = ST_ABS;
            ST_ABS: if (load_sp && !x_known) state_d = ST_REL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_REL;
        else        state_q <= state_d;
    end

    // tracked data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abs_q <= 8'd0;
            ofs_q <= '0;
        end else if (load_sp) begin
            if (x_known) abs_q <= x_value;
            ofs_q <= '0;
        end else begin
            unique case (state_q)
                ST_REL: ofs_q <= ofs_q + {{EXT_OFS{delta[DELTA_W-1]}}, delta};
                ST_ABS: abs_q <= abs_q + {{EXT_ABS{delta[DELTA_W-1]}}, delta};
            endcase
        end
    end

    // outputs
    always_comb begin
        sp_known     = (state_q == ST_ABS);
        offset_valid = (state_q == ST_REL);
        sp_value     = sp_known ? abs_q : 8'd0;
        sp_offset    = sp_known ? '0 : ofs_q;
    end
endmodule

// File: rtl/sp_shadow_chk.sv
module sp_shadow_chk #(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_valid,
    input logic [3:0]       rec_op,
    input logic             sp_known,
    input logic [7:0]       sp_value,
    input logic [OFS_W-1:0] sp_offset,
    input logic             offset_valid
);
    a_r2_call_relative: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_op == 4'd1 && !sp_known) |=>
            (!sp_known && sp_offset == $past(sp_offset) - OFS_W'(2)));

    a_r4_push_absolute: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_op == 4'd5 && sp_known) |=>
            (sp_known && sp_value == $past(sp_value) - 8'd1));

    a_r5_known_only_by_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sp_known) |-> $past(rec_valid && rec_op == 4'd10));

    a_r7_unknown_only_by_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sp_known) |-> ($past(rec_valid && rec_op == 4'd10) && sp_offset == '0));

    a_r10_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_valid) |=> ($stable(sp_offset) && $stable(sp_value) && $stable(sp_known)));

    a_r5_offset_flag: assert property (@(posedge clk) disable iff (!rst_n)
        offset_valid != sp_known);
endmodule

bind sp_shadow_tracker sp_shadow_chk #(.OFS_W(OFS_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_valid    (rec_valid),
    .rec_op       (rec_op),
    .sp_known     (sp_known),
    .sp_value     (sp_value),
    .sp_offset    (sp_offset),
    .offset_valid (offset_valid)
);

// File: tb/sp_shadow_tracker_tb.sv
module sp_shadow_tracker_tb_top;
    localparam int OFS_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rec_valid = 1'b0;
    logic [3:0]       rec_op = 4'd0;
    logic [7:0]       rec_data = 8'd0;
    logic             sp_known;
    logic [7:0]       sp_value;
    logic [OFS_W-1:0] sp_offset;
    logic             offset_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model
    bit               m_known = 0;
    logic [7:0]       m_abs   = 0;
    logic [OFS_W-1:0] m_ofs   = 0;
    bit               mx_known = 0;
    logic [7:0]       mx_val  = 0;

    always #2 clk = ~clk;

    sp_shadow_tracker #(.OFS_W(OFS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_op(rec_op),
        .rec_data(rec_data), .sp_known(sp_known), .sp_value(sp_value),
        .sp_offset(sp_offset), .offset_valid(offset_valid)
    );

    function automatic int op_delta(input logic [3:0] op);
        case (op)
            4'd1: return -2;
            4'd2: return 2;
            4'd3: return 3;
            4'd4: return -3;
            4'd5: return -1;
            4'd6: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic string op_tag(input bit v, input logic [3:0] op);
        if (!v) return "R10";
        case (op)
            4'd1, 4'd2: return "R2";
            4'd3, 4'd4: return "R3";
            4'd5, 4'd6: return "R4";
            4'd7, 4'd10: return "R5";
            4'd8: return "R7";
            4'd9: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step(input bit v, input logic [3:0] op, input logic [7:0] d);
        bit old_known = m_known;
        logic [7:0] old_abs = m_abs;
        if (!v) return;
        if (op == 4'd10) begin
            if (mx_known) begin m_known = 1; m_abs = mx_val; end
            else m_known = 0;
            m_ofs = '0;
        end else if (m_known) begin
            m_abs = m_abs + 8'(op_delta(op));
        end else begin
            m_ofs = m_ofs + OFS_W'(op_delta(op));
        end
        case (op)
            4'd7: begin mx_known = 1; mx_val = d; end
            4'd8: mx_known = 0;
            4'd9: begin mx_known = old_known; mx_val = old_abs; end
            default: ;
        endcase
    endtask

    task automatic check(input string tag);
        logic [7:0]       e_val = m_known ? m_abs : 8'd0;
        logic [OFS_W-1:0] e_ofs = m_known ? '0 : m_ofs;
        n_tests++;
        if (sp_known !== m_known || sp_value !== e_val ||
            sp_offset !== e_ofs || offset_valid !== !m_known) begin
            n_fail++;
            $display("FAIL %s: got known=%0b val=%02h ofs=%0d ov=%0b exp known=%0b val=%02h ofs=%0d ov=%0b",
                     tag, sp_known, sp_value, sp_offset, offset_valid,
                     m_known, e_val, e_ofs, !m_known);
        end
    endtask

    task automatic step(input bit v, input logic [3:0] op, input logic [7:0] d, input string tag);
        @(negedge clk);
        rec_valid = v; rec_op = op; rec_data = d;
        @(posedge clk);
        #1;
        model_step(v, op, d);
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20171026));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        step(1, 4'd1, 8'h00, "R2");            // -2
        step(1, 4'd2, 8'h00, "R2");            // 0
        step(1, 4'd4, 8'h00, "R3");            // -3
        step(1, 4'd3, 8'h00, "R3");            // 0
        step(1, 4'd5, 8'h00, "R4");
        step(1, 4'd6, 8'h00, "R4");
        step(0, 4'd1, 8'h00, "R10");
        step(1, 4'd12, 8'h55, "R10");
        step(1, 4'd0, 8'h55, "R10");
        for (int i = 0; i < 17; i++) step(1, 4'd1, 8'h00, "R9");
        step(1, 4'd9, 8'h00, "R11");           // X unknown
        step(1, 4'd10, 8'h00, "R11");          // stays relative, offset 0
        step(1, 4'd7, 8'h05, "R5");
        step(1, 4'd10, 8'h00, "R5");           // known, 0x05
        for (int i = 0; i < 6; i++) step(1, 4'd5, 8'h00, "R8");   // 0xFF
        step(1, 4'd9, 8'h00, "R6");            // X = 0xFF
        step(1, 4'd1, 8'h00, "R6");
        step(1, 4'd10, 8'h00, "R6");           // back to 0xFF
        step(0, 4'd5, 8'h00, "R10");
        step(1, 4'd8, 8'h00, "R7");
        step(1, 4'd10, 8'h00, "R7");           // relative, offset 0
        step(1, 4'd4, 8'h00, "R7");
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom_range(0, 9) != 0);
            logic [3:0] op = 4'($urandom_range(0, 15));
            logic [7:0] d = 8'($urandom_range(0, 255));
            step(v, op, d, op_tag(v, op));
        end
        finish_run();
    end
endmodule